// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block decides which of three interrupt sources a small 8-bit CPU core takes. The sources are one external line and the overflow events of two timers. A 7-bit control register sits in the core's data space at address 0x0B. It holds a request flag and an enable bit for each source, plus one master enable. Hardware events set the flags. Software can read the register and write it.

On each cycle where `sample_tick` is high, the block looks at the pending requests. A request is pending when its flag and its enable are both set. The block takes the highest-priority pending request if three things hold: the master enable is set, the core's stack is not full, and no call is already outstanding. It then presents a call request carrying a fixed vector address, using a valid/ready handshake:

- `call_valid` stays high, and `call_vector` stays stable, until the core raises `call_ready`.
- The handshake completes on the cycle where both signals are high.
- On that cycle the block clears the request flag that won and clears the master enable.

No further call can be made until the core signals a return-from-interrupt, which sets the master enable again. A plain return has no effect on the master enable.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every control register bit is 0 and `call_valid` is low.
- R2: A write with `reg_wr_en` high and `reg_addr` = 0x0B loads the register. Any write with `reg_addr` ≠ 0x0B has no effect on the register. When `reg_addr` = 0x0B, `reg_rdata` shows the register with this layout:
  - bit 0 = master enable
  - bits 1..3 = enables for external, timer 0 and timer 1
  - bits 4..6 = the matching request flags
  - bit 7 reads 0

  At any other address, `reg_rdata` reads 0x00.
- R3: A high `ext_evt`, `tmr0_evt` or `tmr1_evt` sets its request flag on the next cycle. A flag remains set until it is serviced or software writes a 0 to it.
- R4: A call is launched, with `call_valid` rising one cycle later, only on a cycle where all of the following hold:
  - `sample_tick` is high;
  - the master enable is set;
  - `stack_full` is low;
  - no call is outstanding;
  - at least one source has both its flag and its enable set.

  Requests that arrive between two ticks are evaluated together at the later tick.
- R5: When several requests are pending, the external source wins over timer 0, and timer 0 wins over timer 1. Their vectors are 0x04, 0x08 and 0x0C.
- R6: While `call_valid` is high and `call_ready` is low, `call_valid` and `call_vector` hold. On the handshake cycle:
  - the winning flag clears;
  - the master enable clears;
  - `call_valid` drops;
  - the other flags are untouched.
- R7: `reti_strobe` sets the master enable, overriding a software write in the same cycle. It does not override a handshake in the same cycle. `ret_strobe` never changes the register.
- R8: If a hardware event sets a flag in the same cycle as a software write or a handshake that would clear it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | Sampling strobe; requests are evaluated when it is high |
| ext_evt | input | 1 | External interrupt event, one pulse per event |
| tmr0_evt | input | 1 | Timer 0 overflow event |
| tmr1_evt | input | 1 | Timer 1 overflow event |
| stack_full | input | 1 | Core stack has no free entry |
| ret_strobe | input | 1 | Core executed a plain return |
| reti_strobe | input | 1 | Core executed a return-from-interrupt |
| reg_wr_en | input | 1 | Data-space write strobe |
| reg_addr | input | 8 | Data-space address |
| reg_wdata | input | 8 | Data-space write data |
| reg_rdata | output | 8 | Register read data; 0x00 when the address does not match |
| call_valid | output | 1 | Call request outstanding |
| call_vector | output | 8 | Vector address of the outstanding call |
| call_ready | input | 1 | Core accepts the call |

## Verification
Every register bit can be read, so a wrong flag or enable shows up on `reg_rdata` in the very next cycle. A wrong choice of winner shows up on `call_vector` one cycle after the tick. A lost or stale master enable shows up at the next sampling tick, either as a call that should not happen or as a missing one. The bench compares the full register image, `call_valid` and `call_vector` against a bench-side model on every cycle. Any divergence is therefore caught within one cycle of the state going wrong.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC     = 3;
  localparam int IDXW     = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int EMI_BIT  = 0;
  localparam int EN_LSB   = 1;
  localparam int FLG_LSB  = EN_LSB + NSRC;
  localparam int CTRL_W   = 1 + 2 * NSRC;
  localparam int VEC_BASE = 4;
  localparam int VEC_STEP = 4;

  function automatic logic [7:0] vec_of(input logic [IDXW-1:0] idx);
    return 8'(VEC_BASE + VEC_STEP * int'(idx));
  endfunction
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N    = 3,
  parameter int IDXW = 2
) (
  input  logic [N-1:0]    req,
  output logic            any,
  output logic [IDXW-1:0] idx
);
  logic [N-1:0] grant;

  for (genvar i = 0; i < N; i++) begin : g_grant
    if (i == 0) begin : g_top
      assign grant[i] = req[i];
    end else begin : g_rest
      assign grant[i] = req[i] & ~(|req[i-1:0]);
    end
  end

  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = IDXW'(i);
    end
  end
endmodule

// File: rtl/irq_call_issue.sv
module irq_call_issue #(
  parameter int IDXW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic [IDXW-1:0] launch_idx,
  input  logic            ready,
  output logic            valid,
  output logic [7:0]      vector,
  output logic [IDXW-1:0] idx,
  output logic            accept
);
  import irq_pkg::*;

  assign accept = valid & ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      vector <= '0;
      idx    <= '0;
    end else if (accept) begin
      valid <= 1'b0;
    end else if (launch) begin
      valid  <= 1'b1;
      idx    <= launch_idx;
      vector <= vec_of(launch_idx);
    end
  end
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg #(
  parameter int N      = 3,
  parameter int IDXW   = 2,
  parameter int CTRL_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              reti,
  input  logic              accept,
  input  logic [IDXW-1:0]   acc_idx,
  input  logic [N-1:0]      hw_set,
  output logic [CTRL_W-1:0] ctrl_q
);
  import irq_pkg::*;

  logic [CTRL_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = wdata;
    if (reti) ctrl_d[EMI_BIT] = 1'b1;
    if (accept) begin
      ctrl_d[EMI_BIT] = 1'b0;
      ctrl_d[FLG_LSB + int'(acc_idx)] = 1'b0;
    end
    for (int i = 0; i < N; i++) begin
      if (hw_set[i]) ctrl_d[FLG_LSB + i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter logic [7:0] REG_ADDR = 8'h0B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_tick,
  input  logic       ext_evt,
  input  logic       tmr0_evt,
  input  logic       tmr1_evt,
  input  logic       stack_full,
  input  logic       ret_strobe,
  input  logic       reti_strobe,
  input  logic       reg_wr_en,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       call_valid,
  output logic [7:0] call_vector,
  input  logic       call_ready
);
  import irq_pkg::*;

  logic [CTRL_W-1:0] ctrl_q;
  logic [NSRC-1:0]   evt_vec;
  logic [NSRC-1:0]   pending;
  logic [IDXW-1:0]   pick_idx;
  logic [IDXW-1:0]   acc_idx;
  logic              pick_any;
  logic              accept;
  logic              launch;
  logic              reg_sel;
  logic              unused_ret;

  assign evt_vec    = {tmr1_evt, tmr0_evt, ext_evt};
  assign reg_sel    = (reg_addr == REG_ADDR);
  assign reg_rdata  = reg_sel ? 8'(ctrl_q) : 8'h00;
  assign pending    = ctrl_q[FLG_LSB +: NSRC] & ctrl_q[EN_LSB +: NSRC];
  assign launch     = sample_tick & ctrl_q[EMI_BIT] & ~stack_full & ~call_valid & pick_any;
  assign unused_ret = ret_strobe;

  irq_prio_pick #(.N(NSRC), .IDXW(IDXW)) u_pick (
    .req (pending),
    .any (pick_any),
    .idx (pick_idx)
  );

  irq_call_issue #(.IDXW(IDXW)) u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .launch_idx (pick_idx),
    .ready      (call_ready),
    .valid      (call_valid),
    .vector     (call_vector),
    .idx        (acc_idx),
    .accept     (accept)
  );

  irq_ctrl_reg #(.N(NSRC), .IDXW(IDXW), .CTRL_W(CTRL_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en & reg_sel),
    .wdata   (reg_wdata[CTRL_W-1:0]),
    .reti    (reti_strobe),
    .accept  (accept),
    .acc_idx (acc_idx),
    .hw_set  (evt_vec),
    .ctrl_q  (ctrl_q)
  );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sample_tick,
  input logic       stack_full,
  input logic       reti_strobe,
  input logic [2:0] evt_vec,
  input logic       call_valid,
  input logic       call_ready,
  input logic [7:0] call_vector,
  input logic [6:0] ctrl_q
);
  a_r6_hold_call: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid && !call_ready |=> call_valid && $stable(call_vector));

  a_r6_emi_drop: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid && call_ready |=> !ctrl_q[0]);

  a_r4_launch_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(call_valid) |-> $past(sample_tick) && $past(ctrl_q[0]) && !$past(stack_full));

  a_r5_vector_legal: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid |-> (call_vector == 8'h04 || call_vector == 8'h08 || call_vector == 8'h0C));

  a_r3_ext_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vec[0] |=> ctrl_q[4]);

  a_r8_tmr1_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vec[2] |=> ctrl_q[6]);

  a_r7_reti_emi: assert property (@(posedge clk) disable iff (!rst_n)
    reti_strobe && !(call_valid && call_ready) |=> ctrl_q[0]);
endmodule

bind prio_irq_ctrl irq_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_tick (sample_tick),
  .stack_full  (stack_full),
  .reti_strobe (reti_strobe),
  .evt_vec     (evt_vec),
  .call_valid  (call_valid),
  .call_ready  (call_ready),
  .call_vector (call_vector),
  .ctrl_q      (ctrl_q)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick = 1'b0, ext_evt = 1'b0, tmr0_evt = 1'b0, tmr1_evt = 1'b0;
  logic       stack_full = 1'b0, ret_strobe = 1'b0, reti_strobe = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_addr = 8'h0B, reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       call_valid, call_ready = 1'b0;
  logic [7:0] call_vector;

  int  vectors = 0, miscompares = 0;
  bit  done = 1'b0;

  logic [6:0] m_ctrl  = '0;
  logic       m_valid = 1'b0;
  logic [7:0] m_vec   = '0;
  int         m_idx   = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .ext_evt(ext_evt), .tmr0_evt(tmr0_evt), .tmr1_evt(tmr1_evt),
    .stack_full(stack_full), .ret_strobe(ret_strobe), .reti_strobe(reti_strobe),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .call_valid(call_valid), .call_vector(call_vector),
    .call_ready(call_ready)
  );

  function automatic int pick_src(input logic [6:0] c);
    for (int i = 0; i < 3; i++) if (c[1+i] && c[4+i]) return i;
    return -1;
  endfunction

  task automatic check(input string tag);
    vectors++;
    if (reg_rdata !== {1'b0, m_ctrl}) begin
      miscompares++;
      $display("FAIL %s R2 reg_rdata act=%h exp=%h", tag, reg_rdata, {1'b0, m_ctrl});
    end
    vectors++;
    if (call_valid !== m_valid) begin
      miscompares++;
      $display("FAIL %s R4 call_valid act=%b exp=%b", tag, call_valid, m_valid);
    end
    if (m_valid) begin
      vectors++;
      if (call_vector !== m_vec) begin
        miscompares++;
        $display("FAIL %s R5 call_vector act=%h exp=%h", tag, call_vector, m_vec);
      end
    end
  endtask

  // one cycle: check present state, drive stimulus, advance model
  task automatic cyc(input string tag, input logic tk, input logic [2:0] ev,
                     input logic sf, input logic rdy, input logic rt, input logic rti,
                     input logic wr, input logic [7:0] ad, input logic [7:0] wd);
    logic [6:0] n_ctrl;
    logic       n_valid;
    logic [7:0] n_vec;
    int         n_idx, p;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = 8'h0B;
    #1;
    check(tag);
    sample_tick = tk; {tmr1_evt, tmr0_evt, ext_evt} = ev; stack_full = sf;
    call_ready = rdy; ret_strobe = rt; reti_strobe = rti;
    reg_wr_en = wr; reg_addr = ad; reg_wdata = wd;
    n_ctrl = m_ctrl; n_valid = m_valid; n_vec = m_vec; n_idx = m_idx;
    if (wr && ad == 8'h0B) n_ctrl = wd[6:0];
    if (rti) n_ctrl[0] = 1'b1;
    if (m_valid && rdy) begin
      n_ctrl[0] = 1'b0;
      n_ctrl[4 + m_idx] = 1'b0;
      n_valid = 1'b0;
    end else if (!m_valid && tk && m_ctrl[0] && !sf) begin
      p = pick_src(m_ctrl);
      if (p >= 0) begin
        n_valid = 1'b1; n_idx = p; n_vec = 8'(4 + 4 * p);
      end
    end
    for (int i = 0; i < 3; i++) if (ev[i]) n_ctrl[4 + i] = 1'b1;
    @(posedge clk);
    m_ctrl = n_ctrl; m_valid = n_valid; m_vec = n_vec; m_idx = n_idx;
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 3'b000, 0, 0, 0, 0, 0, 8'h0B, 8'h00);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    idle("R1 reset", 2);
    // R2: layout, bit7 reads 0, other address ignored
    cyc("R2 wr", 0, 3'b000, 0, 0, 0, 0, 1, 8'h0B, 8'hFF);
    cyc("R2 other", 0, 3'b000, 0, 0, 0, 0, 1, 8'h0A, 8'h00);
    @(negedge clk); reg_addr = 8'h0A; #1; vectors++;
    if (reg_rdata !== 8'h00) begin
      miscompares++; $display("FAIL R2 foreign addr act=%h exp=00", reg_rdata);
    end
    cyc("R2 clr", 0, 3'b000, 0, 0, 0, 0, 1, 8'h0B, 8'h00);
    // R3: events latch and persist
    cyc("R3 set", 0, 3'b111, 0, 0, 0, 0, 0, 8'h0B, 8'h00);
    idle("R3 hold", 3);
    // R5: all pending, enabled: external first, then timer0, then timer1
    cyc("R5 en", 0, 3'b000, 0, 0, 0, 0, 1, 8'h0B, 8'h7F);
    cyc("R4 stackfull", 1, 3'b000, 1, 0, 0, 0, 0, 8'h0B, 8'h00);
    cyc("R5 tick", 1, 3'b000, 0, 0, 0, 0, 0, 8'h0B, 8'h00);
    idle("R6 wait", 2);
    cyc("R6 ack", 0, 3'b000, 0, 1, 0, 0, 0, 8'h0B, 8'h00);
    cyc("R7 ret", 1, 3'b000, 0, 0, 1, 0, 0, 8'h0B, 8'h00);
    cyc("R7 reti", 0, 3'b000, 0, 0, 0, 1, 0, 8'h0B, 8'h00);
    cyc("R5 t0", 1, 3'b000, 0, 0, 0, 0, 0, 8'h0B, 8'h00);
    cyc("R6 ack2", 0, 3'b000, 0, 1, 0, 0, 0, 8'h0B, 8'h00);
    cyc("R7 reti2", 0, 3'b000, 0, 0, 0, 1, 0, 8'h0B, 8'h00);
    cyc("R5 t1", 1, 3'b000, 0, 0, 0, 0, 0, 8'h0B, 8'h00);
    cyc("R8 ackset", 0, 3'b100, 0, 1, 0, 0, 0, 8'h0B, 8'h00);
    // R8: event beats software clear in same cycle
    cyc("R8 wrset", 0, 3'b001, 0, 0, 0, 0, 1, 8'h0B, 8'h00);
    idle("R8 after", 2);
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      logic wr;
      logic [7:0] ad;
      wr = ($urandom % 10) == 0;
      ad = (($urandom % 4) == 0) ? 8'h0A : 8'h0B;
      cyc("rand R3 R4 R5 R6 R7 R8", ($urandom % 3) == 0, 3'(($urandom % 5 == 0) ? $urandom : 0),
          ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 20) == 0,
          ($urandom % 8) == 0, wr, ad, 8'($urandom));
    end
    idle("end", 2);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule